// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block guards a processor against a stalled program. A single counter advances on every cycle of a slow timebase clock (nominally 32.768 kHz) and cannot be halted from software. The program must pulse a clear input before the selected timeout expires. The first timeout that goes unserviced raises a one-cycle non-maskable interrupt request and sets a warning flag, which gives firmware a last chance to recover. If a second timeout follows with no clear in between, the block raises a system reset request. That request stays high until the block itself is reset, so the chip's reset logic can OR it with the external reset pin.

A 2-bit code picks one of four timeouts. Each step multiplies the period by four. With the default parameters, codes 0, 1, 2 and 3 give 4096, 16384, 65536 and 262144 cycles, which at 32.768 kHz is 125 ms, 500 ms, 2 s and 8 s. The block captures the code at reset and at every clear, so a new setting cannot shorten a timeout that is already running.

Top module: `wdog_two_stage`

## Requirements
- R1: While reset is high, and on the first cycle after it falls, the NMI pulse, the warning flag and the reset request are all low.
- R2: When the count reaches its period with no clear and no warning pending, the NMI output is high for exactly one cycle and the warning flag goes high, with no reset request. Both follow the period-th rising edge after the count restarted.
- R3: A second consecutive timeout, with the warning still set, raises the reset request. The request stays high, and no further NMI pulse appears, until the reset input is asserted.
- R4: A clear restarts the count from zero and drops the warning flag. A timeout after a clear therefore gives an NMI again and does not give a reset.
- R5: Period code n (0 to 3) gives a timeout of 2^(BASE_LOG2 + STEP_LOG2*n) cycles, which is 4096, 16384, 65536 and 262144 cycles with the defaults.
- R6: The period code is captured only at reset and when a clear is sampled. Changing it at any other time has no effect until the next clear.
- R7: A clear sampled on the same edge at which the count would expire takes priority. No timeout occurs, and the count restarts from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Low-speed timebase clock |
| rst_i | input | 1 | Synchronous active-high reset |
| period_sel_i | input | SEL_W | Timeout code, captured at reset and on clear |
| clr_i | input | 1 | One-cycle restart strobe from software |
| nmi_o | output | 1 | One-cycle non-maskable interrupt request |
| rst_req_o | output | 1 | Sticky system reset request |
| warn_o | output | 1 | First timeout has occurred and has not been cleared |

## Verification
The hardest cases to reach from the ports are a clear that lands exactly on the terminal cycle, and a period change made while a timeout is already running. The bench releases reset on a falling edge and counts rising edges from there. This lets it place the clear strobe on the very edge where the count would expire, and then show that the following timeout comes one full period later. For the period change, it switches the code partway through a short period and confirms that the old period still expires on time. It then issues a clear and confirms that the longer period is only in force from that point on.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  // Number of counter bits that a given period code spans.
  function automatic int unsigned stage_shift(input int unsigned base_log2,
                                              input int unsigned step_log2,
                                              input int unsigned code);
    return base_log2 + step_log2 * code;
  endfunction

  // Width that holds the longest period minus one.
  function automatic int unsigned count_width(input int unsigned base_log2,
                                              input int unsigned step_log2,
                                              input int unsigned n_codes);
    return base_log2 + step_log2 * (n_codes - 1);
  endfunction

endpackage

// File: rtl/wdog_sel_latch.sv
module wdog_sel_latch #(
  parameter int unsigned SEL_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             clr_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic [SEL_W-1:0] act_sel_o
);

  // The period in force only changes when the count restarts.
  always_ff @(posedge clk_i) begin
    if (rst_i || clr_i) begin
      act_sel_o <= sel_i;
    end
  end

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int unsigned SEL_W     = 2,
  parameter int unsigned BASE_LOG2 = 12,
  parameter int unsigned STEP_LOG2 = 2
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             clr_i,
  input  logic [SEL_W-1:0] act_sel_i,
  output logic             ovf_o
);

  localparam int unsigned NSEL  = 1 << SEL_W;
  localparam int unsigned CNT_W = wdog_pkg::count_width(BASE_LOG2, STEP_LOG2, NSEL);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last_val [NSEL];
  logic             at_last;

  // One terminal value for each period code.
  for (genvar g = 0; g < NSEL; g++) begin : g_last
    localparam int unsigned SH = wdog_pkg::stage_shift(BASE_LOG2, STEP_LOG2, g);
    assign last_val[g] = CNT_W'((64'd1 << SH) - 64'd1);
  end

  assign at_last = (cnt_q == last_val[act_sel_i]);
  // A clear on the terminal cycle wins over the timeout.
  assign ovf_o   = at_last && !clr_i;

  always_ff @(posedge clk_i) begin
    if (rst_i || clr_i || at_last) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/wdog_escalate.sv
module wdog_escalate (
  input  logic clk_i,
  input  logic rst_i,
  input  logic clr_i,
  input  logic ovf_i,
  output logic nmi_o,
  output logic warn_o,
  output logic rst_req_o
);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      nmi_o     <= 1'b0;
      warn_o    <= 1'b0;
      rst_req_o <= 1'b0;
    end else begin
      nmi_o <= ovf_i && !warn_o;
      if (clr_i) begin
        warn_o <= 1'b0;
      end else if (ovf_i) begin
        warn_o <= 1'b1;
      end
      if (ovf_i && warn_o) begin
        rst_req_o <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/wdog_two_stage.sv
module wdog_two_stage #(
  parameter int unsigned SEL_W     = 2,
  parameter int unsigned BASE_LOG2 = 12,
  parameter int unsigned STEP_LOG2 = 2
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [SEL_W-1:0] period_sel_i,
  input  logic             clr_i,
  output logic             nmi_o,
  output logic             rst_req_o,
  output logic             warn_o
);

  logic [SEL_W-1:0] act_sel;
  logic             ovf;

  wdog_sel_latch #(
    .SEL_W (SEL_W)
  ) u_sel (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .clr_i     (clr_i),
    .sel_i     (period_sel_i),
    .act_sel_o (act_sel)
  );

  wdog_counter #(
    .SEL_W     (SEL_W),
    .BASE_LOG2 (BASE_LOG2),
    .STEP_LOG2 (STEP_LOG2)
  ) u_cnt (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .clr_i     (clr_i),
    .act_sel_i (act_sel),
    .ovf_o     (ovf)
  );

  wdog_escalate u_esc (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .clr_i     (clr_i),
    .ovf_i     (ovf),
    .nmi_o     (nmi_o),
    .warn_o    (warn_o),
    .rst_req_o (rst_req_o)
  );

endmodule

// File: rtl/wdog_two_stage_chk.sv
module wdog_two_stage_chk #(
  parameter int unsigned SEL_W = 2
) (
  input logic             clk_i,
  input logic             rst_i,
  input logic             clr_i,
  input logic             nmi_o,
  input logic             warn_o,
  input logic             rst_req_o,
  input logic [SEL_W-1:0] act_sel
);

  // R1
  rst_state_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    $past(rst_i) |-> (!nmi_o && !warn_o && !rst_req_o));

  // R2
  nmi_pulse_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    nmi_o |=> !nmi_o);

  // R2
  nmi_warn_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(nmi_o) |-> $rose(warn_o));

  // R3
  rst_req_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    rst_req_o |=> rst_req_o);

  // R3
  rst_req_after_warn_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(rst_req_o) |-> $past(warn_o));

  // R4
  clr_quiet_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    clr_i |=> (!warn_o && !nmi_o));

  // R6
  sel_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !clr_i |=> $stable(act_sel));

endmodule

bind wdog_two_stage wdog_two_stage_chk #(.SEL_W(SEL_W)) u_chk (
  .clk_i     (clk_i),
  .rst_i     (rst_i),
  .clr_i     (clr_i),
  .nmi_o     (nmi_o),
  .warn_o    (warn_o),
  .rst_req_o (rst_req_o),
  .act_sel   (act_sel)
);

// File: tb/wdog_two_stage_tb.sv
`timescale 1ns/1ps
module wdog_two_stage_tb;

  localparam int BASE = 4;
  localparam int STEP = 2;
  localparam int L0 = 1 << BASE;
  localparam int L1 = 1 << (BASE + STEP);
  localparam int L2 = 1 << (BASE + 2 * STEP);
  localparam int L3 = 1 << (BASE + 3 * STEP);

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] sel = 2'd0;
  logic       clr = 1'b0;
  logic       nmi, rst_req, warn;

  int n_chk  = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  wdog_two_stage #(
    .SEL_W     (2),
    .BASE_LOG2 (BASE),
    .STEP_LOG2 (STEP)
  ) u_dut (
    .clk_i        (clk),
    .rst_i        (rst),
    .period_sel_i (sel),
    .clr_i        (clr),
    .nmi_o        (nmi),
    .rst_req_o    (rst_req),
    .warn_o       (warn)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input logic [1:0] code);
    @(negedge clk);
    rst = 1'b1;
    sel = code;
    clr = 1'b0;
    cyc(3);
    rst = 1'b0;
  endtask

  task automatic pulse_clr();
    clr = 1'b1;
    cyc(1);
    clr = 1'b0;
  endtask

  task automatic t_reset_state();
    rst = 1'b1;
    cyc(2);
    chk("R1 nmi in reset", nmi, 0);
    chk("R1 warn in reset", warn, 0);
    chk("R1 rst_req in reset", rst_req, 0);
    do_reset(2'd0);
    cyc(1);
    chk("R1 outputs after release", {nmi, warn, rst_req}, 0);
  endtask

  task automatic t_escalation();
    do_reset(2'd0);
    cyc(L0 - 1);
    chk("R2 no early nmi", nmi, 0);
    chk("R2 no early warn", warn, 0);
    cyc(1);
    chk("R2 nmi on first timeout", nmi, 1);
    chk("R2 warn on first timeout", warn, 1);
    chk("R2 no reset on first timeout", rst_req, 0);
    cyc(1);
    chk("R2 nmi lasts one cycle", nmi, 0);
    chk("R2 warn held", warn, 1);
    cyc(L0 - 2);
    chk("R3 no early reset request", rst_req, 0);
    cyc(1);
    chk("R3 reset request on second timeout", rst_req, 1);
    for (int i = 0; i < 3 * L0; i++) begin
      cyc(1);
      chk("R3 no further nmi", nmi, 0);
    end
    chk("R3 reset request sticky", rst_req, 1);
    do_reset(2'd0);
    cyc(1);
    chk("R3 reset request dropped by reset", rst_req, 0);
  endtask

  task automatic t_periods();
    int lens [4];
    lens[0] = L0; lens[1] = L1; lens[2] = L2; lens[3] = L3;
    for (int c = 0; c < 4; c++) begin
      do_reset(2'(c));
      cyc(lens[c] - 1);
      chk($sformatf("R5 code %0d not yet expired", c), nmi, 0);
      cyc(1);
      chk($sformatf("R5 code %0d expires", c), nmi, 1);
    end
  endtask

  task automatic t_clear();
    do_reset(2'd0);
    cyc(L0);
    chk("R4 warn set before clear", warn, 1);
    pulse_clr();
    chk("R4 clear drops warn", warn, 0);
    cyc(L0 - 1);
    chk("R4 count restarted, no early nmi", nmi, 0);
    cyc(1);
    chk("R4 nmi again after clear", nmi, 1);
    chk("R4 no reset after clear", rst_req, 0);
    do_reset(2'd1);
    for (int i = 0; i < 5; i++) begin
      cyc(L1 - 20);
      pulse_clr();
      chk("R4 regular clears keep warn low", warn, 0);
      chk("R4 regular clears keep reset low", rst_req, 0);
    end
  endtask

  task automatic t_clear_on_terminal();
    do_reset(2'd0);
    cyc(L0 - 1);
    pulse_clr();
    chk("R7 clear on terminal edge blocks nmi", nmi, 0);
    chk("R7 clear on terminal edge blocks warn", warn, 0);
    cyc(L0 - 1);
    chk("R7 restart from zero, no early nmi", nmi, 0);
    cyc(1);
    chk("R7 next timeout one full period later", nmi, 1);
  endtask

  task automatic t_sel_change();
    do_reset(2'd0);
    cyc(5);
    sel = 2'd3;
    cyc(L0 - 6);
    chk("R6 old period still running", nmi, 0);
    cyc(1);
    chk("R6 old period expires on time", nmi, 1);
    pulse_clr();
    cyc(20);
    chk("R6 short period no longer used", nmi, 0);
    chk("R6 no warn after clear", warn, 0);
    cyc(L3 - 21);
    chk("R6 new period not yet expired", nmi, 0);
    cyc(1);
    chk("R6 new period in force after clear", nmi, 1);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: bench hung, actual running expected finished");
    summary();
    $finish;
  end

  initial begin
    t_reset_state();
    t_escalation();
    t_periods();
    t_clear();
    t_clear_on_terminal();
    t_sel_change();
    summary();
    $finish;
  end

endmodule